// File: doc/BRIEF.md
# Spin Sequence Generator with Readout Gaps

The block sets the state of a spin flipper for every beam pulse. The pattern is a fixed eight-step octet. A one-cycle pulse-start strobe moves the block to the next slot. In normal mode the eight slots repeat without a break. In gap mode the frame grows to twelve slots: after every two real steps comes one discard slot. During a discard slot the data is marked invalid and a readout window opens, which gives a slower downstream reader time to move data between pulses. The requested mode is adopted only when a frame wraps back to slot 0. A frame that has started always completes in the mode it started with.

A second function stamps each pulse. A count of microsecond ticks runs between strobes. At each strobe the count is latched as the pulse interval and then restarted, and a pulse number is incremented. The latched interval is compared with a programmable expected period. If the two differ by more than a programmable tolerance, an error flag is raised and held until the next strobe. The same logic serves the slower nominal rate and a faster rate; only the expected period changes.

Top module: `spin_seq_gen`

## Requirements
- R1: After reset: slot_o is 0, spin_o is 1, valid_o is 1, readout_o is 0, pulse_num_o is 0, interval_o is 0 and interval_err_o is 0. The active mode is normal.
- R2: If pulse_i is high at a clock edge, slot_o moves to the next slot of the frame after that edge. At the last slot it wraps to 0. slot_o does not change at an edge where pulse_i is low.
- R3: In normal mode the frame has 8 slots (0 to 7). spin_o for those slots is 1,0,0,1,0,1,1,0. valid_o is 1 and readout_o is 0 in every slot.
- R4: In gap mode the frame has 12 slots (0 to 11). Slots with slot_o mod 3 equal to 2 are gaps: valid_o is 0, readout_o is 1, and spin_o keeps the value of the preceding slot. The other slots carry the octet in order, so spin_o over slots 0 to 11 is 1,0,0,0,1,1,0,1,1,1,0,0.
- R5: The active mode takes the value of gap_mode_i only on a strobe that wraps the slot from the last slot of the frame to 0. A change to gap_mode_i at any other time has no effect until that wrap.
- R6: pulse_num_o increments by one on each strobe.
- R7: On a strobe, interval_o takes the number of us_tick_i pulses seen since the previous strobe or since reset. A tick in the same cycle as the strobe is counted in that interval. The tick count then restarts from zero. interval_o holds its value between strobes.
- R8: On a strobe, interval_err_o is set to 1 if the new interval differs from expect_period_i by more than tolerance_i, and to 0 otherwise. A difference equal to the tolerance is not an error. The flag holds between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Pulse-start strobe, one cycle |
| us_tick_i | input | 1 | Microsecond tick strobe |
| gap_mode_i | input | 1 | Requested mode: 1 = gap frame, 0 = normal frame |
| expect_period_i | input | INT_W | Expected interval in microseconds |
| tolerance_i | input | INT_W | Allowed deviation in microseconds |
| spin_o | output | 1 | Spin flipper state for the current slot |
| valid_o | output | 1 | Current slot carries useful data |
| readout_o | output | 1 | Current slot is a readout gap |
| slot_o | output | SLOT_W | Current slot index |
| interval_o | output | INT_W | Latched interval between the last two strobes |
| pulse_num_o | output | PN_W | Pulse count |
| interval_err_o | output | 1 | Latched interval is out of tolerance |

## Verification
Two events can fall in the same cycle, and each is provoked on purpose. In the first, a microsecond tick arrives together with a strobe. The bench drives both in one cycle and then checks that the tick is counted in the interval that closes at that strobe. The next interval must begin from zero, so the tick is not counted twice. In the second, a frame wraps on the same strobe that adopts a new mode. The bench changes gap_mode_i partway through a frame and checks that slot_o still runs to the old frame's last slot. It then checks that the new frame length and gap pattern start exactly at slot 0.

// File: rtl/spin_seq_pkg.sv
package spin_seq_pkg;
  localparam int unsigned N_STEPS   = 8;
  localparam int unsigned GAP_FRAME = N_STEPS + N_STEPS / 2;
  localparam int unsigned SLOT_W    = $clog2(GAP_FRAME);
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/spin_slot_seq.sv
module spin_slot_seq
  import spin_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  logic  gap_req_i,
  output slot_t slot_o,
  output logic  gap_mode_o
);
  slot_t slot_q, last_slot;
  logic  gap_q;

  assign last_slot = gap_q ? slot_t'(GAP_FRAME - 1) : slot_t'(N_STEPS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      gap_q  <= 1'b0;
    end else if (adv_i) begin
      if (slot_q == last_slot) begin
        slot_q <= '0;
        gap_q  <= gap_req_i;  // mode only changes at frame wrap
      end else begin
        slot_q <= slot_q + slot_t'(1);
      end
    end
  end

  assign slot_o     = slot_q;
  assign gap_mode_o = gap_q;
endmodule

// File: rtl/spin_slot_decode.sv
module spin_slot_decode
  import spin_seq_pkg::*;
#(
  parameter logic [N_STEPS-1:0] PATTERN = 8'b0110_1001
) (
  input  slot_t slot_i,
  input  logic  gap_mode_i,
  output logic  spin_o,
  output logic  valid_o,
  output logic  readout_o
);
  localparam int unsigned EXT_W = 2 ** SLOT_W;

  logic [EXT_W-1:0] pat_ext;
  slot_t grp, pos, step;
  logic  is_gap;

  assign pat_ext = {{(EXT_W - N_STEPS){1'b0}}, PATTERN};

  always_comb begin
    grp    = slot_i / slot_t'(3);
    pos    = slot_i % slot_t'(3);
    is_gap = gap_mode_i && (pos == slot_t'(2));
    // gap slot repeats the second step of its group
    step   = gap_mode_i ? (grp << 1) + (is_gap ? slot_t'(1) : pos) : slot_i;
    spin_o    = pat_ext[step];
    valid_o   = !is_gap;
    readout_o = is_gap;
  end
endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer #(
  parameter int unsigned INT_W = 20,
  parameter int unsigned PN_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             tick_i,
  input  logic [INT_W-1:0] expect_i,
  input  logic [INT_W-1:0] tol_i,
  output logic [INT_W-1:0] interval_o,
  output logic [PN_W-1:0]  pulse_num_o,
  output logic             err_o
);
  logic [INT_W-1:0] cnt_q, cnt_nxt, diff;

  // saturate rather than wrap on a missing strobe
  assign cnt_nxt = (tick_i && (cnt_q != '1)) ? cnt_q + INT_W'(1) : cnt_q;
  assign diff    = (cnt_nxt > expect_i) ? cnt_nxt - expect_i : expect_i - cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      interval_o  <= '0;
      pulse_num_o <= '0;
      err_o       <= 1'b0;
    end else if (pulse_i) begin
      cnt_q       <= '0;
      interval_o  <= cnt_nxt;
      pulse_num_o <= pulse_num_o + PN_W'(1);
      err_o       <= diff > tol_i;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/spin_seq_gen.sv
module spin_seq_gen #(
  parameter int unsigned INT_W = 20,
  parameter int unsigned PN_W  = 16,
  parameter logic [spin_seq_pkg::N_STEPS-1:0] PATTERN = 8'b0110_1001
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            pulse_i,
  input  logic                            us_tick_i,
  input  logic                            gap_mode_i,
  input  logic [INT_W-1:0]                expect_period_i,
  input  logic [INT_W-1:0]                tolerance_i,
  output logic                            spin_o,
  output logic                            valid_o,
  output logic                            readout_o,
  output logic [spin_seq_pkg::SLOT_W-1:0] slot_o,
  output logic [INT_W-1:0]                interval_o,
  output logic [PN_W-1:0]                 pulse_num_o,
  output logic                            interval_err_o
);
  spin_seq_pkg::slot_t slot;
  logic                gap_act;

  spin_slot_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (pulse_i),
    .gap_req_i  (gap_mode_i),
    .slot_o     (slot),
    .gap_mode_o (gap_act)
  );

  spin_slot_decode #(.PATTERN(PATTERN)) u_dec (
    .slot_i     (slot),
    .gap_mode_i (gap_act),
    .spin_o     (spin_o),
    .valid_o    (valid_o),
    .readout_o  (readout_o)
  );

  pulse_interval_timer #(.INT_W(INT_W), .PN_W(PN_W)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_i     (pulse_i),
    .tick_i      (us_tick_i),
    .expect_i    (expect_period_i),
    .tol_i       (tolerance_i),
    .interval_o  (interval_o),
    .pulse_num_o (pulse_num_o),
    .err_o       (interval_err_o)
  );

  assign slot_o = slot;
endmodule

// File: rtl/spin_seq_gen_chk.sv
module spin_seq_gen_chk #(
  parameter int unsigned INT_W = 20,
  parameter int unsigned PN_W  = 16
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            pulse_i,
  input logic                            spin_o,
  input logic                            valid_o,
  input logic                            readout_o,
  input logic [spin_seq_pkg::SLOT_W-1:0] slot_o,
  input logic [INT_W-1:0]                interval_o,
  input logic [PN_W-1:0]                 pulse_num_o,
  input logic                            interval_err_o
);
  localparam int unsigned SW = spin_seq_pkg::SLOT_W;

  // R2
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(slot_o));

  // R2
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i && slot_o != SW'(7) && slot_o != SW'(11) |=> slot_o == $past(slot_o) + SW'(1));

  // R3
  valid_outside_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !readout_o |-> valid_o);

  // R4
  gap_position_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    readout_o |-> (slot_o % SW'(3) == SW'(2)) && !valid_o);

  // R4
  gap_spin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(readout_o) |-> $stable(spin_o));

  // R6
  pulse_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> pulse_num_o == $past(pulse_num_o) + PN_W'(1));

  // R7
  interval_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(interval_o));

  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(interval_err_o));
endmodule

bind spin_seq_gen spin_seq_gen_chk #(.INT_W(INT_W), .PN_W(PN_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pulse_i        (pulse_i),
  .spin_o         (spin_o),
  .valid_o        (valid_o),
  .readout_o      (readout_o),
  .slot_o         (slot_o),
  .interval_o     (interval_o),
  .pulse_num_o    (pulse_num_o),
  .interval_err_o (interval_err_o)
);

// File: tb/spin_seq_gen_tb_top.sv
module spin_seq_gen_tb_top;
  localparam int unsigned INT_W = 20;
  localparam int unsigned PN_W  = 16;
  localparam int unsigned SW    = spin_seq_pkg::SLOT_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pulse_i = 1'b0;
  logic             us_tick_i = 1'b0;
  logic             gap_mode_i = 1'b0;
  logic [INT_W-1:0] expect_period_i = INT_W'(5);
  logic [INT_W-1:0] tolerance_i = INT_W'(1);
  logic             spin_o, valid_o, readout_o, interval_err_o;
  logic [SW-1:0]    slot_o;
  logic [INT_W-1:0] interval_o;
  logic [PN_W-1:0]  pulse_num_o;

  int errors = 0;
  int checks = 0;
  int m_slot = 0;
  int m_gap  = 0;
  int m_pn   = 0;

  int norm_spin [8]  = '{1, 0, 0, 1, 0, 1, 1, 0};
  int gap_spin  [12] = '{1, 0, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0};

  always #5 clk_i = ~clk_i;

  spin_seq_gen dut_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .pulse_i         (pulse_i),
    .us_tick_i       (us_tick_i),
    .gap_mode_i      (gap_mode_i),
    .expect_period_i (expect_period_i),
    .tolerance_i     (tolerance_i),
    .spin_o          (spin_o),
    .valid_o         (valid_o),
    .readout_o       (readout_o),
    .slot_o          (slot_o),
    .interval_o      (interval_o),
    .pulse_num_o     (pulse_num_o),
    .interval_err_o  (interval_err_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) us_tick_i = 1'b1;
      @(negedge clk_i) us_tick_i = 1'b0;
    end
  endtask

  task automatic strobe(bit with_tick);
    @(negedge clk_i);
    pulse_i   = 1'b1;
    us_tick_i = with_tick;
    @(negedge clk_i);
    pulse_i   = 1'b0;
    us_tick_i = 1'b0;
  endtask

  // reference model of the frame, built from R2..R5
  task automatic pulse_and_check(string req);
    int last;
    last = (m_gap != 0) ? 11 : 7;
    if (m_slot == last) begin
      m_slot = 0;
      m_gap  = int'(gap_mode_i);
    end else m_slot++;
    m_pn++;
    strobe(1'b0);
    chk({req, " slot"}, int'(slot_o), m_slot);
    if (m_gap != 0) begin
      chk({req, " R4 spin"}, int'(spin_o), gap_spin[m_slot]);
      chk({req, " R4 readout"}, int'(readout_o), (m_slot % 3 == 2) ? 1 : 0);
      chk({req, " R4 valid"}, int'(valid_o), (m_slot % 3 == 2) ? 0 : 1);
    end else begin
      chk({req, " R3 spin"}, int'(spin_o), norm_spin[m_slot]);
      chk({req, " R3 readout"}, int'(readout_o), 0);
      chk({req, " R3 valid"}, int'(valid_o), 1);
    end
    chk("R6 pulse_num", int'(pulse_num_o), m_pn % (2 ** PN_W));
  endtask

  task automatic t_reset;
    chk("R1 slot", int'(slot_o), 0);
    chk("R1 spin", int'(spin_o), 1);
    chk("R1 valid", int'(valid_o), 1);
    chk("R1 readout", int'(readout_o), 0);
    chk("R1 pulse_num", int'(pulse_num_o), 0);
    chk("R1 interval", int'(interval_o), 0);
    chk("R1 err", int'(interval_err_o), 0);
  endtask

  task automatic t_normal;
    ticks(3);
    chk("R2 no strobe slot", int'(slot_o), 0);
    for (int k = 0; k < 16; k++) pulse_and_check("R3 normal");
  endtask

  task automatic t_mode_switch;
    gap_mode_i = 1'b1;
    for (int k = 0; k < 8; k++) pulse_and_check("R5 pending");
    chk("R5 normal frame kept", int'(slot_o), 0);
    for (int k = 0; k < 5; k++) pulse_and_check("R4 gap");
    gap_mode_i = 1'b0;
    for (int k = 0; k < 7; k++) pulse_and_check("R5 gap kept");
    chk("R5 wrap to zero", int'(slot_o), 0);
    for (int k = 0; k < 9; k++) pulse_and_check("R5 back normal");
  endtask

  task automatic t_interval;
    strobe(1'b0);
    ticks(5); strobe(1'b0);
    chk("R7 interval 5", int'(interval_o), 5);
    chk("R8 exact", int'(interval_err_o), 0);
    ticks(7); strobe(1'b0);
    chk("R7 interval 7", int'(interval_o), 7);
    chk("R8 over", int'(interval_err_o), 1);
    ticks(2);
    chk("R7 hold", int'(interval_o), 7);
    chk("R8 hold", int'(interval_err_o), 1);
    ticks(4); strobe(1'b0);
    chk("R8 edge +tol", int'(interval_err_o), 0);
    ticks(4); strobe(1'b0);
    chk("R8 edge -tol", int'(interval_err_o), 0);
    ticks(3); strobe(1'b0);
    chk("R8 under", int'(interval_err_o), 1);
    ticks(2); strobe(1'b1);
    chk("R7 coincident tick", int'(interval_o), 3);
    strobe(1'b0);
    chk("R7 restart from zero", int'(interval_o), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_normal();
    t_mode_switch();
    t_interval();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule